// File: doc/BRIEF.md
# Debug Bus Request Arbiter

This block decides whether an outside bus master may take over the address and data buses while the processor sits halted in its debug break state. Debug software programs a small write-only control byte through the debug register port: one bit lets external bus requests be honoured, and another bit hands the buses over directly, without any request.

The external request pin is asynchronous, so it is resynchronised before use. A granted request is never acknowledged in the middle of a debug-port transfer. The acknowledge waits for a cycle in which the debug-operation busy flag is low. Once the acknowledge is up, it stays up until the request or the force bit goes away. When the processor leaves the break state, the acknowledge drops at once and the control byte is wiped.

Top module: `dbg_bus_arbiter`

## Requirements
- R1: After reset both `bus_ack` and `bus_to_ext` are 0, and both control bits are 0.
- R2: A write with `reg_wr_en` high, `in_break` high and `reg_wr_addr` equal to 0x17 loads bit 7 of `reg_wr_data` as the request enable and bit 6 as the force bit. A write to any other address changes nothing.
- R3: A write made while `in_break` is low is discarded.
- R4: With the request enable at 0 and the force bit at 0, `bus_ack` stays low whatever `ext_bus_req` does.
- R5: `ext_bus_req` passes through two synchroniser flops. With the enable set and busy low, a request that rises before clock edge k shows on `bus_ack` after edge k+2.
- R6: `bus_ack` can go from low to high only on an edge where `dbg_op_busy` is low. Once high, busy has no effect on it.
- R7: When the request falls before edge k and the force bit is 0, `bus_ack` goes low after edge k+2, one cycle after the synchronised request drops.
- R8: The force bit set to 1 raises `bus_ack` on the next edge with busy low, regardless of the enable and the request. Writing it back to 0 releases `bus_ack` one edge after the write, unless an enabled request is holding it.
- R9: When `in_break` goes low, `bus_ack` drops in the same cycle without waiting for a clock edge, and both control bits clear.
- R10: Bits 5:0 of the written byte have no effect.
- R11: `bus_to_ext` always equals `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_break | input | 1 | Processor is halted in the debug break state |
| reg_wr_en | input | 1 | Debug register write strobe |
| reg_wr_addr | input | 8 | Debug write-space address |
| reg_wr_data | input | 8 | Debug write data |
| dbg_op_busy | input | 1 | A debug-port operation is in flight |
| ext_bus_req | input | 1 | Asynchronous bus request from the external master |
| bus_ack | output | 1 | Bus acknowledge to the external master |
| bus_to_ext | output | 1 | Bus multiplexer select: 1 gives the buses to the external master |

## Verification
The bench sweeps all 256 addresses with the force pattern. A decoder that aliases addresses would raise the acknowledge at the wrong address. It also sweeps all 256 data bytes with a request already held. A design that reads the wrong bit, or lets a reserved bit count, would show the wrong acknowledge for some byte. The bench measures the synchroniser latency on both edges of the request. A design with one stage too few or too many would move the edge by a cycle. The bench also checks that busy holds off only the rising edge, that leaving the break state drops the acknowledge at once and wipes both bits, and that a write made outside the break state is lost.

// File: rtl/dbg_arb_pkg.sv
package dbg_arb_pkg;

    // Control byte held by the register stage
    typedef struct packed {
        logic req_en;   // honour external bus requests
        logic grab;     // force the buses to the external master
    } arb_ctl_t;

    // Grant stage state
    typedef struct packed {
        logic ack;
    } arb_grant_t;

endpackage

// File: rtl/dbg_arb_sync.sv
module dbg_arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[LAST-1:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/dbg_arb_ctl.sv
module dbg_arb_ctl
    import dbg_arb_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] CTL_ADDR = 8'h17,
    parameter int          EN_BIT   = 7,
    parameter int          GRAB_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_break,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output arb_ctl_t      ctl
);
    localparam logic [DW-1:0] LIVE_MASK = (DW'(1) << EN_BIT) | (DW'(1) << GRAB_BIT);

    arb_ctl_t ctl_d, ctl_q;
    logic     hit;
    logic     unused_rsvd;

    // Reserved bits are decoded by nobody
    assign unused_rsvd = ^(wr_data & ~LIVE_MASK);

    always_comb begin
        hit   = wr_en && in_break && (wr_addr == CTL_ADDR);
        ctl_d = ctl_q;
        if (!in_break) begin
            ctl_d = '0;
        end else if (hit) begin
            ctl_d.req_en = wr_data[EN_BIT];
            ctl_d.grab   = wr_data[GRAB_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R3
    clear_outside_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_break |=> (!ctl_q.req_en && !ctl_q.grab));

    // R2
    hold_without_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_break && !(wr_en && wr_addr == CTL_ADDR)) |=> $stable(ctl_q));

endmodule

// File: rtl/dbg_arb_grant.sv
module dbg_arb_grant
    import dbg_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_break,
    input  arb_ctl_t ctl,
    input  logic     req_s,
    input  logic     busy,
    output logic     ack_q
);
    arb_grant_t st_d, st_q;
    logic       want;

    always_comb begin
        want     = ctl.grab || (ctl.req_en && req_s);
        st_d.ack = in_break && want && (st_q.ack || !busy);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_q = st_q.ack;

    // R6
    no_rise_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ack && busy) |=> !st_q.ack);

    // R4
    no_ack_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.req_en && !ctl.grab) |=> !st_q.ack);

    // R7
    release_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ack && !req_s && !ctl.grab) |=> !st_q.ack);

    // R9
    drop_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_break |=> !st_q.ack);

endmodule

// File: rtl/dbg_bus_arbiter.sv
module dbg_bus_arbiter
    import dbg_arb_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 8,
    parameter logic [AW-1:0] CTL_ADDR    = 8'h17,
    parameter int            EN_BIT      = 7,
    parameter int            GRAB_BIT    = 6,
    parameter int            SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_break,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_addr,
    input  logic [DW-1:0] reg_wr_data,
    input  logic          dbg_op_busy,
    input  logic          ext_bus_req,
    output logic          bus_ack,
    output logic          bus_to_ext
);
    arb_ctl_t ctl;
    logic     req_s;
    logic     ack_q;

    dbg_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_bus_req),
        .sync_out (req_s)
    );

    dbg_arb_ctl #(
        .AW(AW), .DW(DW), .CTL_ADDR(CTL_ADDR),
        .EN_BIT(EN_BIT), .GRAB_BIT(GRAB_BIT)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_break (in_break),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .ctl      (ctl)
    );

    dbg_arb_grant u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_break (in_break),
        .ctl      (ctl),
        .req_s    (req_s),
        .busy     (dbg_op_busy),
        .ack_q    (ack_q)
    );

    // Leaving break removes the grant without waiting for an edge
    assign bus_ack    = ack_q && in_break;
    assign bus_to_ext = bus_ack;

    // R8
    grab_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && ctl.grab && in_break) |=> ack_q);

endmodule

// File: tb/sim_dbg_bus_arbiter.sv
`timescale 1ns/1ps
module sim_dbg_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_break = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       busy = 1'b0;
    logic       req = 1'b0;
    logic       ack, to_ext;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    dbg_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .in_break(in_break),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .dbg_op_busy(busy), .ext_bus_req(req),
        .bus_ack(ack), .bus_to_ext(to_ext)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (ack !== exp) begin
            n_bad++;
            $display("FAIL %s: bus_ack=%b expected %b at %0t", tag, ack, exp, $time);
        end
        n_chk++;
        if (to_ext !== ack) begin
            n_bad++;
            $display("FAIL R11: bus_to_ext=%b expected %b at %0t", to_ext, ack, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        step(2);
        chk(1'b0, "R1 in reset");
        rst_n = 1'b1;
        step(2);
        chk(1'b0, "R1 after reset");

        // R2: address sweep with force pattern, no request
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), 8'h40);
            step();
            chk(a == 8'h17, "R2 address decode");
            wr(8'h17, 8'h00);
            step();
            chk(1'b0, "R8 release");
        end

        // R10 / R4: data sweep with request held and synchronised
        req = 1'b1;
        step(3);
        for (int d = 0; d < 256; d++) begin
            wr(8'h17, 8'(d));
            step();
            if (d[7:6] == 2'b00) chk(1'b0, "R4 disabled ignores request");
            else                 chk(d[7] | d[6], "R10 R2 data bits");
            wr(8'h17, 8'h00);
            step();
            chk(1'b0, "R4 cleared enable");
        end

        // R5: synchroniser latency on rising request
        req = 1'b0;
        step(3);
        wr(8'h17, 8'h80);
        step();
        req = 1'b1;
        step(); chk(1'b0, "R5 edge1");
        step(); chk(1'b0, "R5 edge2");
        step(); chk(1'b1, "R5 edge3");

        // R7: release latency
        req = 1'b0;
        step(); chk(1'b1, "R7 edge1");
        step(); chk(1'b1, "R7 edge2");
        step(); chk(1'b0, "R7 edge3");

        // R6: busy holds off the rise only
        busy = 1'b1; req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step(); chk(1'b0, "R6 busy blocks rise");
        end
        busy = 1'b0;
        step(); chk(1'b1, "R6 rise after busy");
        busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(); chk(1'b1, "R6 busy ignored once granted");
        end
        busy = 1'b0;
        req = 1'b0;
        wr(8'h17, 8'h00);
        step(3);
        chk(1'b0, "R7 idle");

        // R8: force without enable or request, and under busy
        wr(8'h17, 8'h40);
        step(); chk(1'b1, "R8 force on");
        wr(8'h17, 8'h00);
        step(); chk(1'b0, "R8 force off");
        busy = 1'b1;
        wr(8'h17, 8'h40);
        step(3); chk(1'b0, "R8 R6 force waits for busy");
        busy = 1'b0;
        step(); chk(1'b1, "R8 force after busy");

        // R8: clearing force while an enabled request is held keeps grant
        wr(8'h17, 8'hC0);
        req = 1'b1;
        step(3);
        wr(8'h17, 8'h80);
        step(2); chk(1'b1, "R8 request keeps grant");

        // R9: break exit drops at once and wipes bits
        wr(8'h17, 8'hC0);
        step();
        chk(1'b1, "R9 precondition");
        in_break = 1'b0;
        #1 chk(1'b0, "R9 immediate drop");
        step();
        in_break = 1'b1;
        step(3); chk(1'b0, "R9 bits cleared");

        // R3: writes outside break are lost
        in_break = 1'b0;
        wr(8'h17, 8'hC0);
        in_break = 1'b1;
        step(3); chk(1'b0, "R3 write outside break");

        finish_run();
    end
endmodule